// File: doc/BRIEF.md
# Nonvolatile Write Unlock Controller

This block sits between a host register bus and an on-chip nonvolatile store. The store holds two spaces: a program space of 14-bit words and a data space of bytes. The host loads an address, loads a data value and then requests a read or a write through a control register. A write is accepted only when a two-byte key has been written to a write-only unlock port by the two bus writes that come immediately before the start request. A stray or out-of-order bus write therefore cannot start a write by accident.

Once a write is accepted, the controller owns it. It latches the operands, runs the write for a fixed number of clock cycles and then writes the word into the array. At the end it raises a completion flag. A program-space write also drives a stall output, which holds instruction fetch for the whole write while the clock keeps running. Reads return data after a latency that depends on the space: one cycle for the data space and three cycles for the program space. The array is a plain synchronous register array. The parameter `WR_CYCLES` sets the write duration.

Top module: `nvm_unlock_ctrl`

## Requirements
- R1: A write starts only if the two bus writes immediately before the start request are 0x55 and then 0xAA, both to the unlock port (offset 5). The start request is a write to control (offset 4) with bit 1 set. Any other sequence drops the request: it covers a missing key, an extra value between the two key bytes, the key bytes in reversed order, or another register write between the key and the request. After a dropped request, control bit 1 stays 0, no completion is flagged and the array is unchanged.
- R2: Reading the unlock port (offset 5) always returns 0x00.
- R3: Control bit 1 (write busy) and bit 0 (read busy) are set by host requests. Only the hardware clears them, when the operation completes. A host write of 0 to these bits while the operation runs leaves them at 1.
- R4: A write starts only if bit 2 (write enable) of the start-request write is 1. Clearing the enable bit while a write runs does not stop or alter that write.
- R5: Control bit 7 selects the space for the request. A value of 1 selects the program space: the word address is {address-high offset 3 bits 4:0, address-low offset 2} and the word is {data-high offset 1 bits 5:0, data-low offset 0}. A value of 0 selects the data space: the byte address is address-low and the byte is data-low. The two spaces are independent.
- R6: Control bit 3 (error) becomes 1 when a reset arrives while a write is in progress. It reads 0 after a write completes normally.
- R7: A write keeps control bit 1 high for exactly `WR_CYCLES` clock cycles. At its end, control bit 4 and the `done_irq` output become 1. A control write with bit 4 at 0 clears the flag.
- R8: After a read request, a data-space read clears bit 0 and updates data-low one cycle later. A program-space read does so three cycles later and updates both data registers.
- R9: `fetch_stall` is 1 for every cycle of a program-space write and 0 at all other times, including during data-space writes and during reads.
- R10: A read or write request made while an operation is in progress is ignored. This holds even if a valid key preceded it. The running operation keeps its own address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Host register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Register read data (combinational on bus_addr) |
| fetch_stall | output | 1 | Holds instruction fetch during a program-space write |
| done_irq | output | 1 | Write-completion flag |

## Verification
The hardest situations to reach from the ports involve timing rather than values. One is a reset that lands in the middle of a timed write. Another is a fully keyed request that arrives while a write is still running. The bench reaches both by starting a write and then, within the shortened write window, either pulling reset or issuing a second key and request to a different address. It then reads both addresses back and checks them. The key sequence is also corrupted at random in a share of the random operations, with each kind of corruption chosen separately.

// File: rtl/nvm_unlock_ctrl.sv
module nvm_unlock_ctrl #(
  parameter int WR_CYCLES = 4000,
  parameter int PGM_DEPTH = 1024,
  parameter int DAT_DEPTH = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       fetch_stall,
  output logic       done_irq
);
  localparam int PAW = $clog2(PGM_DEPTH);
  localparam int DAW = $clog2(DAT_DEPTH);
  localparam int CW  = $clog2(WR_CYCLES + 1);
  localparam logic [2:0] A_DLO = 3'd0, A_DHI = 3'd1, A_ALO = 3'd2,
                         A_AHI = 3'd3, A_CTL = 3'd4, A_KEY = 3'd5;
  localparam logic [1:0] K_IDLE = 2'd0, K_HALF = 2'd1, K_ARMED = 2'd2;

  logic [7:0]  dlo, alo;
  logic [5:0]  dhi;
  logic [4:0]  ahi;
  logic        tgt, wen, done_q, err_q;
  logic [1:0]  key_st, rd_cnt;
  logic        wr_busy, rd_busy, op_tgt;
  logic [12:0] op_addr;
  logic [13:0] op_data;
  logic [CW-1:0] cnt;
  logic [13:0] pmem [PGM_DEPTH];
  logic [7:0]  dmem [DAT_DEPTH];

  wire wr_ctl   = bus_we && bus_addr == A_CTL;
  wire busy     = wr_busy || rd_busy;
  wire start_wr = wr_ctl && bus_wdata[1] && bus_wdata[2] && key_st == K_ARMED && !busy;
  wire start_rd = wr_ctl && bus_wdata[0] && !busy && !start_wr;
  wire wr_end   = wr_busy && cnt == CW'(WR_CYCLES - 1);
  wire rd_end   = rd_busy && rd_cnt == 2'd0;
  wire [13:0] rd_word = op_tgt ? pmem[op_addr[PAW-1:0]] : {6'd0, dmem[op_addr[DAW-1:0]]};

  assign fetch_stall = wr_busy && op_tgt;
  assign done_irq    = done_q;

  always_comb begin
    case (bus_addr)
      A_DLO:   bus_rdata = dlo;
      A_DHI:   bus_rdata = {2'b00, dhi};
      A_ALO:   bus_rdata = alo;
      A_AHI:   bus_rdata = {3'b000, ahi};
      A_CTL:   bus_rdata = {tgt, 2'b00, done_q, err_q, wen, wr_busy, rd_busy};
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q   <= err_q | wr_busy;
      {dlo, dhi, alo, ahi} <= '0;
      {tgt, wen, done_q}   <= '0;
      key_st  <= K_IDLE;
      wr_busy <= 1'b0;
      rd_busy <= 1'b0;
      rd_cnt  <= 2'd0;
      cnt     <= '0;
      op_tgt  <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      if (bus_we) begin
        case (bus_addr)
          A_DLO: dlo <= bus_wdata;
          A_DHI: dhi <= bus_wdata[5:0];
          A_ALO: alo <= bus_wdata;
          A_AHI: ahi <= bus_wdata[4:0];
          A_CTL: begin
            tgt <= bus_wdata[7];
            wen <= bus_wdata[2];
            if (!bus_wdata[4]) done_q <= 1'b0;
          end
          default: ;
        endcase
        if (bus_addr != A_KEY)          key_st <= K_IDLE;
        else if (bus_wdata == 8'h55)    key_st <= K_HALF;
        else if (bus_wdata == 8'hAA && key_st == K_HALF) key_st <= K_ARMED;
        else                            key_st <= K_IDLE;
      end
      if (start_wr || start_rd) begin
        op_tgt  <= bus_wdata[7];
        op_addr <= {ahi, alo};
        op_data <= {dhi, dlo};
      end
      if (start_wr) begin
        wr_busy <= 1'b1;
        cnt     <= '0;
      end else if (wr_end) begin
        wr_busy <= 1'b0;
        done_q  <= 1'b1;
        err_q   <= 1'b0;
      end else if (wr_busy) begin
        cnt <= cnt + 1'b1;
      end
      if (start_rd) begin
        rd_busy <= 1'b1;
        rd_cnt  <= bus_wdata[7] ? 2'd2 : 2'd0;
      end else if (rd_end) begin
        rd_busy <= 1'b0;
        dlo     <= rd_word[7:0];
        if (op_tgt) dhi <= rd_word[13:8];
      end else if (rd_busy) begin
        rd_cnt <= rd_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && wr_end) begin
      if (op_tgt) pmem[op_addr[PAW-1:0]] <= op_data;
      else        dmem[op_addr[DAW-1:0]] <= op_data[7:0];
    end
  end

  AST_START_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_busy) |-> $past(key_st) == K_ARMED && $past(wr_ctl)); // R1
  AST_UNKEYED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) wr_ctl && key_st != K_ARMED && !wr_busy |=> !wr_busy); // R1
  AST_WEN_GATES_START: assert property (@(posedge clk) disable iff (!rst_n) wr_ctl && !bus_wdata[2] && !wr_busy |=> !wr_busy); // R4
  AST_WR_HELD_TO_END: assert property (@(posedge clk) disable iff (!rst_n) wr_busy && !wr_end |=> wr_busy); // R3
  AST_DONE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $rose(done_q) |-> $past(wr_busy) && !wr_busy); // R7
  AST_DATA_RD_LAT: assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_busy) && !op_tgt |=> !rd_busy); // R8
  AST_PGM_RD_LAT: assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_busy) && op_tgt |=> rd_busy ##1 rd_busy ##1 !rd_busy); // R8
  AST_STALL_ON_PGM: assert property (@(posedge clk) disable iff (!rst_n) $rose(fetch_stall) |-> $past(wr_ctl && bus_wdata[7])); // R9
  AST_OPERAND_HELD: assert property (@(posedge clk) disable iff (!rst_n) (wr_busy && !wr_end) || (rd_busy && !rd_end) |=> $stable(op_addr) && $stable(op_tgt) && $stable(op_data)); // R10
endmodule

// File: tb/nvm_unlock_ctrl_tb.sv
module nvm_unlock_ctrl_tb_top;
  localparam int WRC = 20;
  localparam logic [2:0] DLO = 3'd0, DHI = 3'd1, ALO = 3'd2, AHI = 3'd3, CTL = 3'd4, KEY = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic fetch_stall, done_irq;
  int n_chk = 0, n_bad = 0;

  logic [13:0] m_pmem [1024];
  logic        m_pval [1024];
  logic [7:0]  m_dmem [256];
  logic        m_dval [256];

  always #5 clk = ~clk;

  nvm_unlock_ctrl #(.WR_CYCLES(WRC), .PGM_DEPTH(1024), .DAT_DEPTH(256)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .fetch_stall(fetch_stall), .done_irq(done_irq));

  function automatic int exp_latency(input logic t);
    return t ? 3 : 1;
  endfunction

  function automatic logic key_ok(input int mode);
    return mode == 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic do_write(input logic t, input logic [12:0] a, input logic [13:0] d, input int mode);
    logic [7:0] v;
    int cyc;
    string tag;
    tag = (mode == 5) ? "R4" : "R1";
    wr(ALO, a[7:0]); wr(AHI, {3'b0, a[12:8]});
    wr(DLO, d[7:0]); wr(DHI, {2'b0, d[13:8]});
    case (mode)
      0, 5: begin wr(KEY, 8'h55); wr(KEY, 8'hAA); end
      2: begin wr(KEY, 8'h55); wr(KEY, 8'h3C); wr(KEY, 8'hAA); end
      3: begin wr(KEY, 8'h55); wr(KEY, 8'hAA); wr(ALO, a[7:0]); end
      4: begin wr(KEY, 8'hAA); wr(KEY, 8'h55); end
      default: ;
    endcase
    wr(CTL, {t, 4'b0000, (mode != 5), 2'b10});
    rreg(CTL, v);
    check(tag, int'(v[1]), int'(key_ok(mode)));
    if (key_ok(mode)) begin
      cyc = 0;
      while (v[1] && cyc < WRC + 10) begin
        check("R9", int'(fetch_stall), int'(t));
        step(); cyc++; rreg(CTL, v);
      end
      check("R7", cyc, WRC);
      check("R7", int'(v[4]), 1);
      check("R7", int'(done_irq), 1);
      check("R6", int'(v[3]), 0);
      check("R9", int'(fetch_stall), 0);
      if (t) begin m_pmem[a[9:0]] = d; m_pval[a[9:0]] = 1'b1; end
      else   begin m_dmem[a[7:0]] = d[7:0]; m_dval[a[7:0]] = 1'b1; end
    end else begin
      repeat (WRC + 2) step();
      rreg(CTL, v);
      check(tag, int'(v[1]), 0);
      check(tag, int'(done_irq), 0);
    end
  endtask

  task automatic do_read(input logic t, input logic [12:0] a, input string req);
    logic [7:0] v, lo, hi;
    int n;
    wr(ALO, a[7:0]); wr(AHI, {3'b0, a[12:8]});
    wr(CTL, {t, 6'b000000, 1'b1});
    rreg(CTL, v);
    n = 0;
    while (v[0] && n < 10) begin
      check("R9", int'(fetch_stall), 0);
      step(); n++; rreg(CTL, v);
    end
    check("R8", n, exp_latency(t));
    rreg(DLO, lo); rreg(DHI, hi);
    if (t) begin
      if (m_pval[a[9:0]]) check(req, int'({hi[5:0], lo}), int'(m_pmem[a[9:0]]));
    end else begin
      if (m_dval[a[7:0]]) check(req, int'(lo), int'(m_dmem[a[7:0]]));
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h1F3A5));
    for (int i = 0; i < 1024; i++) m_pval[i] = 1'b0;
    for (int i = 0; i < 256; i++)  m_dval[i] = 1'b0;
    repeat (4) step();
    rst_n = 1'b1;
    step();
    // reset state
    rreg(CTL, v);
    check("R3", int'(v & 8'h97), 0);
    rreg(KEY, v);
    check("R2", int'(v), 0);
    check("R9", int'(fetch_stall), 0);
    check("R7", int'(done_irq), 0);

    // data space then program space at aliased low address
    do_write(1'b0, 13'h0A3, 14'h005A, 0);
    do_write(1'b1, 13'h01A3, 14'h2B7C, 0);
    do_read(1'b0, 13'h0A3, "R5");
    do_read(1'b1, 13'h01A3, "R5");
    wr(KEY, 8'h55);
    rreg(KEY, v);
    check("R2", int'(v), 0);

    // corrupted keys and disabled write
    do_write(1'b0, 13'h012, 14'h0011, 0);
    for (int m = 1; m <= 5; m++) begin
      do_write(1'b0, 13'h012, 14'(8'h20 + m), m);
      do_read(1'b0, 13'h012, (m == 5) ? "R4" : "R1");
    end
    do_write(1'b1, 13'h0155, 14'h1234, 0);
    do_write(1'b1, 13'h0155, 14'h3FFF, 3);
    do_read(1'b1, 13'h0155, "R1");

    // clear during write, request while busy
    do_write(1'b0, 13'h041, 14'h0077, 0);
    wr(ALO, 8'h40); wr(AHI, 8'h00); wr(DLO, 8'hC3);
    wr(KEY, 8'h55); wr(KEY, 8'hAA); wr(CTL, 8'h06);
    wr(CTL, 8'h00);
    rreg(CTL, v);
    check("R3", int'(v[1]), 1);
    wr(ALO, 8'h41); wr(DLO, 8'h99);
    wr(KEY, 8'h55); wr(KEY, 8'hAA); wr(CTL, 8'h07);
    rreg(CTL, v);
    check("R10", int'(v[0]), 0);
    for (int k = 0; k < WRC + 5 && v[1]; k++) begin step(); rreg(CTL, v); end
    check("R4", int'(v[1]), 0);
    m_dmem[8'h40] = 8'hC3; m_dval[8'h40] = 1'b1;
    do_read(1'b0, 13'h040, "R4");
    do_read(1'b0, 13'h041, "R10");

    // reset while a write runs
    wr(ALO, 8'h66); wr(AHI, 8'h00); wr(DLO, 8'h5E);
    wr(KEY, 8'h55); wr(KEY, 8'hAA); wr(CTL, 8'h06);
    repeat (5) step();
    rst_n = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    step();
    rreg(CTL, v);
    check("R6", int'(v[3]), 1);
    check("R3", int'(v[1]), 0);
    m_dval[8'h66] = 1'b0;
    do_write(1'b0, 13'h067, 14'h0042, 0);
    wr(CTL, 8'h00);
    check("R7", int'(done_irq), 0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic t;
      logic [12:0] a;
      logic [13:0] d;
      int mode;
      t = 1'($urandom % 2);
      a = t ? 13'($urandom % 1024) : 13'($urandom % 256);
      d = t ? 14'($urandom) : 14'($urandom % 256);
      mode = ($urandom % 4 == 0) ? int'(1 + $urandom % 5) : 0;
      do_write(t, a, d, mode);
      do_read(t, a, key_ok(mode) ? "R5" : ((mode == 5) ? "R4" : "R1"));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule